// File: doc/BRIEF.md
# Checkpoint Restart Controller for Error and Mispredict Recovery

This block keeps a saved copy of the architectural state as it stood after the most recent instruction that completed correctly. The saved copy is the address of the next instruction and a small snapshot of the register file. Each accepted commit replaces the copy with that instruction's address plus the instruction size and the registers presented with it. The surrounding pipeline is not part of the block.

A branch mispredict and a detected hardware error use the same recovery path. The hardware error can be, for example, a parity or residue mismatch from any of several checkers. On a request the controller stops instruction issue and pulses a flush of all in-flight work. It then presents the saved restart address and register snapshot, and releases issue after that.

A retry counter tracks errors that occur with no commit between them. When the error limit is already used up and one more error arrives, the controller does not retry. It raises a fatal indication and holds issue stopped until reset.

Top module: `retry_ctrl`

## Requirements
- R1: After synchronous reset, `issue_stall`, `flush`, `restart_valid` and `fatal` are 0. The saved restart address is `RESET_PC` and the saved register snapshot is all zeros.
- R2: A commit accepted while the controller is running (`cm_valid`=1) saves `cm_pc + PC_STEP` as the restart address and `cm_regs` as the snapshot. The saved values are seen at the next recovery.
- R3: When any bit of `err_in` is 1 or `mispred` is 1 while running, `flush` is 1 for exactly one cycle, starting in the cycle after the request. `issue_stall` is 1 from that same cycle.
- R4: In the cycle after the flush pulse, `restart_valid` is 1 for one cycle and carries the saved address on `restart_pc` and the saved snapshot on `restore_regs`. `issue_stall` is 1 in that cycle and returns to 0 in the following cycle.
- R5: A mispredict follows the same flush and restart sequence as an error. A mispredict neither advances nor clears the retry count.
- R6: If an error and a mispredict are present in the same cycle, the request is handled as an error and counts toward the retry limit.
- R7: A commit presented in the same cycle as a recovery request is discarded, and the saved state keeps its earlier value.
- R8: Errors, mispredicts and commits presented during the flush or restart cycles are ignored. They cause no second flush and do not change the saved state.
- R9: Each accepted commit clears the retry count. An error that arrives after `RETRY_MAX` errors with no commit between them raises `fatal` in the next cycle, with no flush and no restart. `fatal` and `issue_stall` then stay at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_valid | input | 1 | An instruction completed correctly this cycle |
| cm_pc | input | ADDR_W | Address of the completed instruction |
| cm_regs | input | NREG*REG_W | Register snapshot after the completed instruction |
| err_in | input | ERR_N | Error flags from the hardware checkers, one per source |
| mispred | input | 1 | Branch mispredict recovery request |
| issue_stall | output | 1 | Stop issuing new instructions |
| flush | output | 1 | One-cycle clear of all in-flight state |
| restart_valid | output | 1 | Restart address and snapshot are valid |
| restart_pc | output | ADDR_W | Address at which fetch restarts |
| restore_regs | output | NREG*REG_W | Register snapshot to restore |
| fatal | output | 1 | Retry limit exceeded; stays set until reset |

## Verification
The bench builds the block with `RETRY_MAX` = 3, so the fatal path is reached after four error requests with no commit between them, and the priority case fits after three errors. It sets `RESET_PC` to a non-zero value, so a recovery right after reset can be told apart from an all-zero default. It keeps the default four 8-bit registers, so one 32-bit word of distinct bytes covers every snapshot lane. It uses all four error inputs, which confirms that any single source starts recovery.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_RESTORE = 2'd2,
    ST_HALT    = 2'd3
  } rc_state_t;
endpackage

// File: rtl/rc_ckpt_store.sv
module rc_ckpt_store #(
  parameter int ADDR_W = 32,
  parameter int REG_W = 8,
  parameter int NREG = 4,
  parameter int PC_STEP = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_pc,
  input  logic [NREG*REG_W-1:0]   wr_regs,
  output logic [ADDR_W-1:0]       ck_pc,
  output logic [NREG*REG_W-1:0]   ck_regs
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) ck_pc <= RESET_PC;
    else if (wr_en) ck_pc <= wr_pc + STEP;
  end

  // one saved lane per architectural register
  for (genvar g = 0; g < NREG; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) ck_regs[g*REG_W +: REG_W] <= '0;
      else if (wr_en) ck_regs[g*REG_W +: REG_W] <= wr_regs[g*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/rc_retry_cnt.sv
module rc_retry_cnt #(
  parameter int RETRY_MAX = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int CNT_W = $clog2(RETRY_MAX + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RETRY_MAX);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == LIMIT);
endmodule

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SNAP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_err,
  input  logic               req_mis,
  input  logic               exhausted,
  input  logic [ADDR_W-1:0]  ck_pc,
  input  logic [SNAP_W-1:0]  ck_regs,
  output logic               running,
  output logic               issue_stall,
  output logic               flush,
  output logic               restart_valid,
  output logic [ADDR_W-1:0]  restart_pc,
  output logic [SNAP_W-1:0]  restore_regs,
  output logic               fatal
);
  rc_state_t state;

  assign running = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      issue_stall   <= 1'b0;
      flush         <= 1'b0;
      restart_valid <= 1'b0;
      restart_pc    <= '0;
      restore_regs  <= '0;
      fatal         <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          flush         <= 1'b0;
          restart_valid <= 1'b0;
          if (req_err && exhausted) begin
            state       <= ST_HALT;
            fatal       <= 1'b1;
            issue_stall <= 1'b1;
          end else if (req_err || req_mis) begin
            state       <= ST_FLUSH;
            flush       <= 1'b1;
            issue_stall <= 1'b1;
          end else begin
            issue_stall <= 1'b0;
          end
        end
        ST_FLUSH: begin
          flush         <= 1'b0;
          restart_valid <= 1'b1;
          restart_pc    <= ck_pc;
          restore_regs  <= ck_regs;
          state         <= ST_RESTORE;
        end
        ST_RESTORE: begin
          restart_valid <= 1'b0;
          issue_stall   <= 1'b0;
          state         <= ST_RUN;
        end
        default: begin
          issue_stall <= 1'b1;
          fatal       <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl #(
  parameter int ADDR_W = 32,
  parameter int REG_W = 8,
  parameter int NREG = 4,
  parameter int ERR_N = 4,
  parameter int RETRY_MAX = 3,
  parameter int PC_STEP = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cm_valid,
  input  logic [ADDR_W-1:0]      cm_pc,
  input  logic [NREG*REG_W-1:0]  cm_regs,
  input  logic [ERR_N-1:0]       err_in,
  input  logic                   mispred,
  output logic                   issue_stall,
  output logic                   flush,
  output logic                   restart_valid,
  output logic [ADDR_W-1:0]      restart_pc,
  output logic [NREG*REG_W-1:0]  restore_regs,
  output logic                   fatal
);
  localparam int SNAP_W = NREG * REG_W;

  logic              err_any, running, exhausted, commit_ok, cnt_inc;
  logic [ADDR_W-1:0] ck_pc;
  logic [SNAP_W-1:0] ck_regs;

  assign err_any   = |err_in;
  assign commit_ok = running && cm_valid && !err_any && !mispred;
  assign cnt_inc   = running && err_any;

  rc_ckpt_store #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .NREG(NREG),
    .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_store (
    .clk(clk), .rst(rst), .wr_en(commit_ok), .wr_pc(cm_pc),
    .wr_regs(cm_regs), .ck_pc(ck_pc), .ck_regs(ck_regs)
  );

  rc_retry_cnt #(.RETRY_MAX(RETRY_MAX)) u_cnt (
    .clk(clk), .rst(rst), .clr(commit_ok), .inc(cnt_inc),
    .exhausted(exhausted)
  );

  rc_seq #(.ADDR_W(ADDR_W), .SNAP_W(SNAP_W)) u_seq (
    .clk(clk), .rst(rst), .req_err(err_any), .req_mis(mispred),
    .exhausted(exhausted), .ck_pc(ck_pc), .ck_regs(ck_regs),
    .running(running), .issue_stall(issue_stall), .flush(flush),
    .restart_valid(restart_valid), .restart_pc(restart_pc),
    .restore_regs(restore_regs), .fatal(fatal)
  );
endmodule

// File: rtl/rc_checker.sv
module rc_checker (
  input logic clk,
  input logic rst,
  input logic issue_stall,
  input logic flush,
  input logic restart_valid,
  input logic fatal
);
  p_flush_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);
  p_flush_stall_r3: assert property (@(posedge clk) disable iff (rst)
    flush |-> issue_stall);
  p_restart_follows_r4: assert property (@(posedge clk) disable iff (rst)
    flush |=> restart_valid && issue_stall);
  p_no_reflush_r8: assert property (@(posedge clk) disable iff (rst)
    restart_valid |=> !flush && !restart_valid);
  p_fatal_hold_r9: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal && issue_stall);
  p_fatal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    fatal |-> !flush && !restart_valid);
endmodule

bind retry_ctrl rc_checker u_chk (
  .clk(clk), .rst(rst), .issue_stall(issue_stall), .flush(flush),
  .restart_valid(restart_valid), .fatal(fatal)
);

// File: tb/sim_retry_ctrl.sv
`timescale 1ns/1ps
module sim_retry_ctrl;
  localparam logic [31:0] RST_PC = 32'h0000_0080;
  localparam int LIM = 3;

  typedef struct packed {
    logic [1:0]  op;   // 0 commit, 1 error, 2 mispredict, 3 both
    logic [31:0] pc;
    logic [31:0] regs;
    logic        fat;  // expected fatal after the request
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{2'd0, 32'h0000_0100, 32'h1122_3344, 1'b0},
    '{2'd1, 32'h0,         32'h0,         1'b0},
    '{2'd0, 32'h0000_0200, 32'h5566_7788, 1'b0},
    '{2'd2, 32'h0,         32'h0,         1'b0},
    '{2'd3, 32'h0,         32'h0,         1'b0},
    '{2'd0, 32'h0000_03FC, 32'h9ABC_DEF0, 1'b0},
    '{2'd1, 32'h0,         32'h0,         1'b0},
    '{2'd1, 32'h0,         32'h0,         1'b0},
    '{2'd2, 32'h0,         32'h0,         1'b0},
    '{2'd0, 32'h0000_0000, 32'hCAFE_BABE, 1'b0},
    '{2'd1, 32'h0,         32'h0,         1'b0}
  };

  logic        clk = 1'b0, rst = 1'b1, cm_valid = 1'b0, mispred = 1'b0;
  logic [31:0] cm_pc = '0, cm_regs = '0;
  logic [3:0]  err_in = '0;
  logic        issue_stall, flush, restart_valid, fatal;
  logic [31:0] restart_pc, restore_regs;

  int nchk = 0, nfail = 0;
  logic [31:0] m_pc, m_regs;
  int m_cnt;
  int err_sel = 0;

  always #2.5 clk = ~clk;

  retry_ctrl #(.RETRY_MAX(LIM), .RESET_PC(RST_PC)) u0 (
    .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_pc(cm_pc),
    .cm_regs(cm_regs), .err_in(err_in), .mispred(mispred),
    .issue_stall(issue_stall), .flush(flush), .restart_valid(restart_valid),
    .restart_pc(restart_pc), .restore_regs(restore_regs), .fatal(fatal)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_pc = RST_PC; m_regs = '0; m_cnt = 0;
  endtask

  task automatic do_commit(input logic [31:0] pc, input logic [31:0] regs);
    @(negedge clk); cm_valid = 1'b1; cm_pc = pc; cm_regs = regs;
    @(negedge clk); cm_valid = 1'b0;
    m_pc = pc + 32'd4; m_regs = regs;            // R2 model
    m_cnt = 0;
  endtask

  // one recovery request; optional commit and disturbances during recovery
  task automatic do_req(input logic [1:0] op, input bit with_commit, input bit disturb);
    bit is_err = op[0];
    bit go_fatal = is_err && (m_cnt == LIM);
    @(negedge clk);
    err_in = is_err ? (4'b0001 << err_sel) : 4'b0;
    err_sel = (err_sel + 1) % 4;
    mispred = op[1];
    if (with_commit) begin cm_valid = 1'b1; cm_pc = 32'hDEAD_0000; cm_regs = 32'hFFFF_FFFF; end
    @(negedge clk);
    cm_valid = 1'b0;
    err_in = disturb ? 4'b1000 : 4'b0;
    mispred = disturb;
    if (disturb) begin cm_valid = 1'b1; cm_pc = 32'hBEEF_0000; cm_regs = 32'h0101_0101; end
    if (go_fatal) begin
      check("R9 fatal", {31'b0, fatal}, 32'd1);
      check("R9 no flush", {31'b0, flush}, 32'd0);
      check("R9 stall", {31'b0, issue_stall}, 32'd1);
      err_in = '0; mispred = 1'b0; cm_valid = 1'b0;
      repeat (4) @(negedge clk);
      check("R9 fatal held", {30'b0, fatal, issue_stall}, 32'd3);
      check("R9 no restart", {31'b0, restart_valid}, 32'd0);
      return;
    end
    if (is_err) m_cnt++;
    check("R3 flush", {31'b0, flush}, 32'd1);
    check("R3 stall", {31'b0, issue_stall}, 32'd1);
    check("R4 not yet valid", {31'b0, restart_valid}, 32'd0);
    @(negedge clk);
    check("R3 flush one cycle", {31'b0, flush}, 32'd0);
    check("R4 restart valid", {31'b0, restart_valid}, 32'd1);
    check("R4 restart pc", restart_pc, m_pc);
    check("R4 restore regs", restore_regs, m_regs);
    check("R4 stall during restart", {31'b0, issue_stall}, 32'd1);
    err_in = '0; mispred = 1'b0; cm_valid = 1'b0;
    @(negedge clk);
    check("R4 stall released", {31'b0, issue_stall}, 32'd0);
    check("R8 no second flush", {30'b0, flush, restart_valid}, 32'd0);
    check("R9 not fatal", {31'b0, fatal}, 32'd0);
  endtask

  initial begin
    #1ms;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 outputs", {28'b0, issue_stall, flush, restart_valid, fatal}, 32'd0);
    do_req(2'd1, 0, 0);   // R1 restart from reset checkpoint

    // table walk: R2 R3 R4 R5 R6
    foreach (VEC[i]) begin
      if (VEC[i].op == 2'd0) do_commit(VEC[i].pc, VEC[i].regs);
      else do_req(VEC[i].op, 0, 0);
      check("R5 table fatal", {31'b0, fatal}, {31'b0, VEC[i].fat});
    end

    // R7 commit together with request is discarded
    do_commit(32'h0000_1000, 32'h0A0B_0C0D);
    do_req(2'd1, 1, 0);
    do_req(2'd2, 1, 0);

    // R8 requests and commit during recovery ignored
    do_req(2'd2, 0, 1);
    do_req(2'd1, 0, 0);

    // R9 / R5: three errors, mispredicts do not clear count, fourth error fatal
    do_reset();
    do_commit(32'h0000_2000, 32'h1357_9BDF);
    do_req(2'd1, 0, 0); do_req(2'd1, 0, 0); do_req(2'd1, 0, 0);
    do_req(2'd2, 0, 0); do_req(2'd2, 0, 0);
    do_req(2'd1, 0, 0);

    // R6: error plus mispredict at the limit counts as error -> fatal
    do_reset();
    check("R1 fatal cleared", {31'b0, fatal}, 32'd0);
    do_req(2'd1, 0, 0); do_req(2'd1, 0, 0); do_req(2'd1, 0, 0);
    do_req(2'd3, 0, 0);

    // R9 commit clears the count
    do_reset();
    do_req(2'd1, 0, 0); do_req(2'd1, 0, 0); do_req(2'd1, 0, 0);
    do_commit(32'h0000_3000, 32'h2468_ACE0);
    do_req(2'd1, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule